// File: doc/BRIEF.md
# Hang-up and Low-Voltage Fault Supervisor

This block watches over the CPU of a small microcontroller and decides when the chip must be forced back through reset. It holds the CPU's return-address stack: five entries of 13 bits, enough for a call chain of two levels with up to three nested interrupts on top. It also holds a software watchdog that counts a periodic tick and must be cleared by the program before it reaches its terminal count. It takes in a flag from an external low-supply comparator. Stack overflow, stack underflow, watchdog expiry and low supply each set a sticky fault flag. Any flag set drives one open-drain output low, and that output is meant to be tied straight to the chip's reset pin.

Push and pop are single-cycle strobes with no back-pressure. The stack accepts every strobe on the cycle it arrives. A push it cannot hold is dropped and recorded as a fault. It does not stall the CPU. The popped address is registered and held until the next pop. The output `fault_drv_o` is the pull-down enable of the open-drain pad: 1 pulls the pin low, 0 releases it to high impedance. Flags and the pin drive are cleared only by the block's own reset.

Top module: `hangup_supervisor`

## Requirements
- R1: The stack is last-in first-out with STACK_DEPTH (default 5) entries of ADDR_W (default 13) bits, and `depth_o` reports the number of held entries, from 0 to STACK_DEPTH.
- R2: A pop from a non-empty stack places the most recently pushed address on `pop_addr_o` after that clock edge, lowers `depth_o` by one, and `pop_addr_o` keeps that value until the next pop.
- R3: A push while `depth_o` equals STACK_DEPTH is discarded: depth and stored entries are unchanged, and the overflow flag `flt_ovf_o` is set.
- R4: A pop while the stack is empty drives `pop_addr_o` to 0, leaves `depth_o` at 0, and sets the underflow flag `flt_unf_o`.
- R5: When push and pop are strobed in the same cycle, only the pop is performed and the pushed address is dropped; a push cannot raise an overflow in that cycle.
- R6: The watchdog counts cycles with `wdt_tick_i` high; `wdt_clear_i` returns it to zero and wins over a tick in the same cycle; the WDT_LIMIT-th counted tick since the last clear sets `flt_wdt_o` at that clock edge.
- R7: `lowv_i` is passed through a two-stage synchronizer, so a level high at one rising edge sets `flt_lv_o` at the third rising edge, even when the level lasted only one cycle.
- R8: Every fault flag is sticky until `rst_n` is asserted, and `fault_drv_o` is 1 exactly when at least one flag is set, from the same clock edge.
- R9: While and after reset, `depth_o`, `pop_addr_o`, all four flags and `fault_drv_o` are 0 and the watchdog count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_addr_i | input | 13 | Return address to push |
| pop_addr_o | output | 13 | Last popped address, 0 after underflow |
| depth_o | output | 3 | Held entries |
| wdt_clear_i | input | 1 | Watchdog clear |
| wdt_tick_i | input | 1 | Watchdog count enable |
| lowv_i | input | 1 | Low-supply comparator level (asynchronous) |
| flt_ovf_o | output | 1 | Sticky stack overflow flag |
| flt_unf_o | output | 1 | Sticky stack underflow flag |
| flt_wdt_o | output | 1 | Sticky watchdog expiry flag |
| flt_lv_o | output | 1 | Sticky low-supply flag |
| fault_drv_o | output | 1 | Open-drain pull-down enable, 1 = pin driven low |

## Verification
The assertions check on every cycle that depth stays within range and that a refused push leaves it at full. They also check that an empty pop yields zero, that a same-cycle push and pop lowers the depth by one, that a clear zeroes the watchdog count, that no flag ever falls back, and that the pin drive matches the flag set. Only the bench scenarios can show the stored order of the addresses across pushes and pops, and the exact tick on which the watchdog fires. They are also needed to show the three-edge delay from the low-supply level to its flag, and that a single-cycle level is not lost.

// File: rtl/hus_pkg.sv
package hus_pkg;
  typedef struct packed {
    logic ovf;
    logic unf;
    logic wdt;
    logic lv;
  } hus_flags_t;
endpackage

// File: rtl/hus_ret_stack.sv
module hus_ret_stack #(
  parameter int STACK_DEPTH = 5,
  parameter int ADDR_W      = 13,
  localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] dout,
  output logic [DW-1:0]     depth,
  output logic              ovf_ev,
  output logic              unf_ev
);
  logic [ADDR_W-1:0] mem [STACK_DEPTH];
  logic [ADDR_W-1:0] top;
  logic              full, empty, wr, rd;

  assign full   = (depth == DW'(STACK_DEPTH));
  assign empty  = (depth == '0);
  assign wr     = push && !pop && !full;
  assign rd     = pop && !empty;
  assign ovf_ev = push && !pop && full;
  assign unf_ev = pop && empty;

  // one register per entry, written only when it is the next free slot
  for (genvar g = 0; g < STACK_DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                      mem[g] <= '0;
      else if (wr && depth == DW'(g))  mem[g] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < STACK_DEPTH; i++)
      if (depth == DW'(i + 1)) top = mem[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      dout  <= '0;
    end else begin
      if (wr)      depth <= depth + 1'b1;
      else if (rd) depth <= depth - 1'b1;
      if (pop)     dout  <= empty ? '0 : top;
    end
  end

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(STACK_DEPTH)); // R1
  AST_OVF_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && depth == DW'(STACK_DEPTH)) |=> depth == DW'(STACK_DEPTH)); // R3
  AST_UNF_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && depth == '0) |=> (dout == '0 && depth == '0)); // R4
  AST_POP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && depth != '0) |=> depth == $past(depth) - 1'b1); // R5
endmodule

// File: rtl/hus_watchdog.sv
module hus_watchdog #(
  parameter int WDT_LIMIT = 1024,
  localparam int CW       = (WDT_LIMIT > 1) ? $clog2(WDT_LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic expire_ev
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end    = (cnt == CW'(WDT_LIMIT - 1));
  assign expire_ev = tick && !clear && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (tick)    cnt <= at_end ? '0 : cnt + 1'b1;
  end

  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0); // R6
  AST_WDT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WDT_LIMIT - 1)); // R6
endmodule

// File: rtl/hus_fault_latch.sv
module hus_fault_latch
  import hus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_ev,
  input  logic       unf_ev,
  input  logic       wdt_ev,
  input  logic       lowv_async,
  output hus_flags_t flags,
  output logic       fault_drv
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lv_sync;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n)      sync_q[s] <= 1'b0;
      else if (s == 0) sync_q[s] <= lowv_async;
      else             sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
    end
  end
  assign lv_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags     <= '0;
      fault_drv <= 1'b0;
    end else begin
      flags.ovf <= flags.ovf | ovf_ev;
      flags.unf <= flags.unf | unf_ev;
      flags.wdt <= flags.wdt | wdt_ev;
      flags.lv  <= flags.lv  | lv_sync;
      fault_drv <= fault_drv | ovf_ev | unf_ev | wdt_ev | lv_sync;
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flags) & ~flags) == '0); // R8
  AST_PIN_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_drv == (flags != '0)); // R8
endmodule

// File: rtl/hangup_supervisor.sv
module hangup_supervisor
  import hus_pkg::*;
#(
  parameter int STACK_DEPTH = 5,
  parameter int ADDR_W      = 13,
  parameter int WDT_LIMIT   = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] pop_addr_o,
  output logic [DW-1:0]     depth_o,
  input  logic              wdt_clear_i,
  input  logic              wdt_tick_i,
  input  logic              lowv_i,
  output logic              flt_ovf_o,
  output logic              flt_unf_o,
  output logic              flt_wdt_o,
  output logic              flt_lv_o,
  output logic              fault_drv_o
);
  logic       ovf_ev, unf_ev, wdt_ev;
  hus_flags_t flags;

  hus_ret_stack #(.STACK_DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i), .din(push_addr_i),
    .dout(pop_addr_o), .depth(depth_o), .ovf_ev(ovf_ev), .unf_ev(unf_ev)
  );

  hus_watchdog #(.WDT_LIMIT(WDT_LIMIT)) u_wdt (
    .clk(clk), .rst_n(rst_n), .tick(wdt_tick_i), .clear(wdt_clear_i),
    .expire_ev(wdt_ev)
  );

  hus_fault_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk(clk), .rst_n(rst_n), .ovf_ev(ovf_ev), .unf_ev(unf_ev),
    .wdt_ev(wdt_ev), .lowv_async(lowv_i), .flags(flags), .fault_drv(fault_drv_o)
  );

  assign flt_ovf_o = flags.ovf;
  assign flt_unf_o = flags.unf;
  assign flt_wdt_o = flags.wdt;
  assign flt_lv_o  = flags.lv;

  AST_RESET_RELEASED_QUIET: assert property (@(posedge clk)
    $rose(rst_n) |-> (depth_o == '0 && !fault_drv_o)); // R9
endmodule

// File: tb/hangup_supervisor_bench.sv
`timescale 1ns/1ps
module hangup_supervisor_bench;
  localparam int LIM = 8;
  localparam int SD  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, clr = 1'b0, tick = 1'b0, lv = 1'b0;
  logic [12:0] pdata = '0;
  logic [12:0] pop_addr;
  logic [2:0]  depth;
  logic        f_ovf, f_unf, f_wdt, f_lv, drv;

  always #10 clk = ~clk;

  hangup_supervisor #(.WDT_LIMIT(LIM)) u_hangup_supervisor (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .push_addr_i(pdata),
    .pop_addr_o(pop_addr), .depth_o(depth), .wdt_clear_i(clr), .wdt_tick_i(tick),
    .lowv_i(lv), .flt_ovf_o(f_ovf), .flt_unf_o(f_unf), .flt_wdt_o(f_wdt),
    .flt_lv_o(f_lv), .fault_drv_o(drv)
  );

  typedef struct {
    logic [12:0] addr;
    int          dep;
    logic [3:0]  fl;   // ovf, unf, wdt, lv
    logic        drv;
    string       tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, fails = 0;
  bit done = 0;

  // reference model state
  int          stk[$];
  logic [12:0] m_addr;
  logic [3:0]  m_fl;
  int          m_cnt;
  logic        m_p1, m_p2;

  function automatic void model_reset();
    stk.delete(); m_addr = '0; m_fl = '0; m_cnt = 0; m_p1 = 0; m_p2 = 0;
  endfunction

  function automatic void model_edge(bit pu, bit po, logic [12:0] d, bit c, bit t, bit l);
    if (po) begin
      if (stk.size() == 0) begin m_addr = '0; m_fl[2] = 1'b1; end
      else m_addr = 13'(stk.pop_back());
    end else if (pu) begin
      if (stk.size() == SD) m_fl[3] = 1'b1;
      else stk.push_back(int'(d));
    end
    if (c) m_cnt = 0;
    else if (t) begin
      if (m_cnt == LIM - 1) begin m_cnt = 0; m_fl[1] = 1'b1; end
      else m_cnt++;
    end
    if (m_p2) m_fl[0] = 1'b1;
    m_p2 = m_p1; m_p1 = l;
  endfunction

  task automatic step(bit pu, bit po, logic [12:0] d, bit c, bit t, bit l, string tag);
    exp_t e;
    push = pu; pop = po; pdata = d; clr = c; tick = t; lv = l;
    model_edge(pu, po, d, c, t, l);
    @(posedge clk); #1;
    e.addr = m_addr; e.dep = stk.size(); e.fl = m_fl; e.drv = (m_fl != '0); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    push = 0; pop = 0; clr = 0; tick = 0;
  endtask

  task automatic do_reset();
    exp_t e;
    rst_n = 0; push = 0; pop = 0; clr = 0; tick = 0; lv = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    e.addr = '0; e.dep = 0; e.fl = '0; e.drv = 0; e.tag = "R9 reset state";
    q.push_back(e);
    @(negedge clk);
    rst_n = 1;
  endtask

  // monitor: compare each expected item against the ports
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] got;
      e = q.pop_front();
      got = {f_ovf, f_unf, f_wdt, f_lv};
      vectors++;
      if (pop_addr !== e.addr || int'(depth) != e.dep || got !== e.fl || drv !== e.drv) begin
        fails++;
        $display("FAIL %s: addr=%h depth=%0d flags=%b drv=%b expected addr=%h depth=%0d flags=%b drv=%b",
                 e.tag, pop_addr, depth, got, drv, e.addr, e.dep, e.fl, e.drv);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 R2: fill to full, pop back in reverse order
    for (int i = 0; i < SD; i++) step(1, 0, 13'(16'h0100 + i * 16'h0111), 0, 0, 0, "R1 push fill");
    step(0, 1, '0, 0, 0, 0, "R2 pop top");
    step(0, 0, '0, 0, 0, 0, "R2 pop value held");
    step(0, 1, '0, 0, 0, 0, "R2 pop second");
    step(1, 0, 13'h1ABC, 0, 0, 0, "R1 push after pops");
    step(0, 1, '0, 0, 0, 0, "R2 pop newest");
    // R5: simultaneous push and pop
    step(1, 1, 13'h0777, 0, 0, 0, "R5 push+pop pop wins");
    step(0, 1, '0, 0, 0, 0, "R5 dropped push not stored");
    step(0, 1, '0, 0, 0, 0, "R1 pop to empty");
    // R3: overflow
    for (int i = 0; i < SD; i++) step(1, 0, 13'(i + 1), 0, 0, 0, "R3 refill");
    step(1, 0, 13'h1FFF, 0, 0, 0, "R3 overflow push dropped");
    step(0, 0, '0, 0, 0, 0, "R8 overflow flag sticky");
    step(0, 1, '0, 0, 0, 0, "R3 top unchanged after overflow");
    do_reset();
    // R4: underflow; R8 then cleared by reset
    step(0, 1, '0, 0, 0, 0, "R4 underflow pop");
    step(1, 0, 13'h0042, 0, 0, 0, "R8 underflow flag sticky");
    step(0, 1, '0, 0, 0, 0, "R2 pop after underflow");
    do_reset();
    // R6: watchdog, clear in the middle, clear wins over tick
    for (int i = 0; i < LIM - 2; i++) step(0, 0, '0, 0, 1, 0, "R6 ticks below limit");
    step(0, 0, '0, 1, 1, 0, "R6 clear wins over tick");
    for (int i = 0; i < LIM - 1; i++) step(0, 0, '0, 0, 1, 0, "R6 ticks to limit-1");
    step(0, 0, '0, 0, 0, 0, "R6 idle no count");
    step(0, 0, '0, 0, 1, 0, "R6 terminal tick fires");
    step(0, 0, '0, 1, 0, 0, "R8 clear does not drop flag");
    do_reset();
    // R7: one-cycle low-supply level
    step(0, 0, '0, 0, 0, 1, "R7 level sampled");
    step(0, 0, '0, 0, 0, 0, "R7 second edge no flag");
    step(0, 0, '0, 0, 0, 0, "R7 third edge flag");
    step(0, 0, '0, 0, 0, 0, "R8 low-supply flag sticky");
    do_reset();
    step(0, 0, '0, 0, 0, 0, "R9 idle after reset");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule